// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host I/O port and a PCI configuration requester. It watches two 32-bit I/O ports. The first is an address selector, which holds an enable flag, a bus number, a device number, a function number and a register number. The second is a data window. When the selector is enabled, an access to the data window becomes one configuration request on an abstract downstream request port. A bus number of zero gives a local (Type 0) request, and the device number is turned into a one-hot IDSEL line. Any other bus number gives a bridged (Type 1) request.

Some accesses are not handled by this block. These are narrow accesses to the selector, data-window accesses while the selector is disabled, and any other address. For these the block raises a pass-through flag so that the ordinary I/O path can service them. If the selector points at bus 0, device 0, the block raises a select for the host's own configuration space instead. Device numbers on bus 0 that have no IDSEL line are completed locally: a read returns all ones and a write is dropped.

A host holds `h_req` and its qualifiers steady until it sees a one-cycle `h_ready`. Only one downstream request is in flight at a time.

Top module: `pci_cfg_xlat`

## Requirements
- R1: After reset, `h_ready` and `ds_valid` are low, and a 4-byte read of the selector port (default 0x0CF8) returns 0x00000000.
- R2: A 4-byte write (`h_size[1]`=1) to the selector port stores the enable (bit 31), bus (23:16), device (15:11), function (10:8) and register (7:2) fields. A 4-byte read returns them with bits 30:24 and 1:0 as zero. Both accesses complete with one `h_ready` pulse.
- R3: A 1- or 2-byte access (`h_size` 00 or 01) anywhere in the selector port's four bytes raises `h_passthru`, never raises `h_ready`, and leaves the stored selector unchanged.
- R4: While the enable bit is 0, an access to the data window (default 0x0CFC–0x0CFF) raises `h_passthru` and issues no downstream request.
- R5: With bus 0 and device d in 1..21, the request's `ds_ad` has only bit 10+d set within bits 31:11. Bits 10:2 carry the function and register fields, and bits 1:0 are 00. `ds_cmd` is {0, write}.
- R6: With a nonzero bus, `ds_ad` is {8'h00, bus, device, function, register, 2'b01} and `ds_cmd` is {1, write}.
- R7: With bus 0 and device 0, a data-window access raises `h_int_sel`, issues no downstream request and never raises `h_ready`.
- R8: With bus 0 and device 22..31, a data-window read completes with `h_rdata` = 0xFFFFFFFF. A write completes as well. Neither issues a downstream request.
- R9: The data-window offset `o` = `h_addr[1:0]` and the size set `ds_be`: a byte gives 1<<o, a word gives 3<<o, and 4 bytes give 1111. `ds_wdata` is `h_wdata` shifted up by 8·o, with lanes that are not enabled set to zero. A read returns the downstream data shifted down by 8·o, and bytes beyond the access size are zero.
- R10: At most one downstream request is outstanding. The request holds `ds_ad`, `ds_cmd`, `ds_be` and `ds_wdata` steady until `ds_ready`. `h_ready` pulses in the cycle after the handshake and never while `ds_valid` is high, so a request whose target answers after L wait cycles completes L+2 cycles after `h_req` is sampled.
- R11: Accesses to any address outside both ports raise `h_passthru` and are otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_addr | input | ADDR_W | Host I/O byte address |
| h_size | input | 2 | 00 byte, 01 word, 1x four bytes |
| h_write | input | 1 | 1 = write, 0 = read |
| h_wdata | input | 32 | Host write data, low-aligned |
| h_rdata | output | 32 | Host read data, low-aligned |
| h_ready | output | 1 | One-cycle completion pulse |
| h_passthru | output | 1 | Access belongs to the ordinary I/O path |
| h_int_sel | output | 1 | Access targets the host's own configuration space |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream request accepted and completed |
| ds_ad | output | 32 | Address-phase value |
| ds_cmd | output | 2 | Bit 1 = bridged type, bit 0 = write |
| ds_be | output | 4 | Active-high byte enables |
| ds_wdata | output | 32 | Lane-placed write data |
| ds_rdata | input | 32 | Read data, valid with `ds_ready` |

## Verification
A corrupted selector register shows up on the next 4-byte read of the selector port. It shows up sooner, in the same request, as a wrong IDSEL bit, a wrong type code or wrong low AD bits on the first data-window access. A wrong lane shift is visible in `ds_be` and `ds_wdata` when the request is issued, and in `h_rdata` on the completion pulse. A handshake state that is out of step shows within one cycle, as `h_ready` rising while a request is still valid, or as a valid request whose fields change before acceptance.

// File: rtl/pci_cfg_pkg.sv
// Shared types for the configuration access translator.
// Assumes a 32-bit data path and the standard selector field layout.
package pci_cfg_pkg;

    // Where a host access is steered.
    typedef enum logic [2:0] {
        RT_PASS,      // ordinary I/O path
        RT_SEL_WR,    // 4-byte write of the selector
        RT_SEL_RD,    // 4-byte read of the selector
        RT_HOST,      // host's own configuration space
        RT_CFG,       // downstream configuration request
        RT_NODEV      // no IDSEL line: complete locally
    } route_t;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE
    } state_t;

    // Stored selector fields (reserved and type bits are not kept).
    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regno;
    } sel_t;

    localparam logic [1:0] TT_LOCAL  = 2'b00;
    localparam logic [1:0] TT_BRIDGE = 2'b01;

    // Read-back image of the selector with zeroed reserved/type bits.
    function automatic logic [31:0] sel_image(input sel_t s);
        return {s.en, 7'b0, s.bus, s.dev, s.fn, s.regno, 2'b00};
    endfunction

endpackage

// File: rtl/cfg_sel_reg.sv
// Selector storage.
// Holds the enable, bus, device, function and register fields;
// assumes the caller strobes load only for a qualified 4-byte write.
module cfg_sel_reg
    import pci_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  sel_t d,
    output sel_t q
);

    // Capture a new selector value on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cfg_route.sv
// Access classifier and address-phase builder.
// Purely combinational. Assumes the IDSEL field ends at bit 31 and starts
// above bit 10, so the function/register bits pass through untouched.
module cfg_route
    import pci_cfg_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [ADDR_W-1:0] WIN_PORT = 16'h0CFC,
    parameter int               IDSEL_LO = 11,
    parameter int               IDSEL_N  = 21
) (
    input  logic [ADDR_W-3:0] port_word,
    input  logic              wide,
    input  logic              write,
    input  sel_t              cur,
    output route_t            route,
    output logic              bridged,
    output logic [31:0]       ad
);

    localparam int IDSEL_HI = IDSEL_LO + IDSEL_N - 1;

    logic [IDSEL_N-1:0] idsel;
    logic               sel_hit;
    logic               win_hit;
    logic [31:0]        ad_local;
    logic [31:0]        ad_bridge;

    // One comparator per IDSEL line: device g+1 drives line g.
    for (genvar g = 0; g < IDSEL_N; g++) begin : g_idsel
        assign idsel[g] = (cur.dev == 5'(g + 1));
    end

    assign sel_hit = (port_word == SEL_PORT[ADDR_W-1:2]);
    assign win_hit = (port_word == WIN_PORT[ADDR_W-1:2]);

    // Assemble the local-bus address phase.
    always_comb begin
        ad_local = '0;
        ad_local[IDSEL_HI:IDSEL_LO] = idsel;
        ad_local[10:2] = {cur.fn, cur.regno};
        ad_local[1:0]  = TT_LOCAL;
    end

    // Assemble the bridged address phase.
    assign ad_bridge = {8'h00, cur.bus, cur.dev, cur.fn, cur.regno, TT_BRIDGE};

    // Decide where the access goes.
    always_comb begin
        route   = RT_PASS;
        bridged = (cur.bus != 8'h00);
        if (sel_hit) begin
            if (wide) begin
                route = write ? RT_SEL_WR : RT_SEL_RD;
            end
        end else if (win_hit && cur.en) begin
            if (bridged) begin
                route = RT_CFG;
            end else if (cur.dev == 5'd0) begin
                route = RT_HOST;
            end else if (|idsel) begin
                route = RT_CFG;
            end else begin
                route = RT_NODEV;
            end
        end
    end

    assign ad = bridged ? ad_bridge : ad_local;

endmodule

// File: rtl/cfg_lanes.sv
// Byte-lane steering for the data window.
// Turns offset and size into byte enables, places write data on lanes
// and aligns read data down. Assumes 4-byte accesses start at lane 0.
module cfg_lanes #(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [1:0]                  size,
    input  logic [DATA_W-1:0]           wdata_in,
    input  logic [DATA_W-1:0]           rdata_in,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           wdata_out,
    output logic [DATA_W-1:0]           rdata_out
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0]  eoff;
    logic [OFF_W:0]    nlanes;
    logic [DATA_W-1:0] wshift;
    logic [DATA_W-1:0] rshift;

    // Effective offset and lane count from the access size.
    always_comb begin
        eoff = size[1] ? '0 : off;
        case (size)
            2'b00:   nlanes = (OFF_W + 1)'(1);
            2'b01:   nlanes = (OFF_W + 1)'(2);
            default: nlanes = (OFF_W + 1)'(LANES);
        endcase
    end

    assign wshift = wdata_in << {eoff, 3'b000};
    assign rshift = rdata_in >> {eoff, 3'b000};

    // Per-lane enable and data masking.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W:0] IDX = (OFF_W + 1)'(g);
        assign be[g] = (IDX >= {1'b0, eoff}) && ((IDX - {1'b0, eoff}) < nlanes);
        assign wdata_out[8*g +: 8] = be[g] ? wshift[8*g +: 8] : 8'h00;
        assign rdata_out[8*g +: 8] = (IDX < nlanes) ? rshift[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/pci_cfg_xlat.sv
// Configuration access translator top.
// Decodes the selector port and data window, issues one downstream
// configuration request at a time and completes local accesses itself.
// Assumes the host holds h_req and its qualifiers until h_ready.
module pci_cfg_xlat
    import pci_cfg_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [ADDR_W-1:0] WIN_PORT = 16'h0CFC,
    parameter int               IDSEL_LO = 11,
    parameter int               IDSEL_N  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic              h_write,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              h_ready,
    output logic              h_passthru,
    output logic              h_int_sel,
    output logic              ds_valid,
    input  logic              ds_ready,
    output logic [31:0]       ds_ad,
    output logic [1:0]        ds_cmd,
    output logic [3:0]        ds_be,
    output logic [31:0]       ds_wdata,
    input  logic [31:0]       ds_rdata
);

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    state_t            state;
    sel_t              cur;
    sel_t              sel_d;
    route_t            route;
    logic              bridged;
    logic [31:0]       ad;
    logic [LANES-1:0]  be;
    logic [DATA_W-1:0] wlane;
    logic [DATA_W-1:0] ralign;
    logic              sel_load;

    assign sel_d = '{en: h_wdata[31], bus: h_wdata[23:16], dev: h_wdata[15:11],
                     fn: h_wdata[10:8], regno: h_wdata[7:2]};
    assign sel_load = (state == ST_IDLE) && h_req && (route == RT_SEL_WR);

    cfg_sel_reg u_sel (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sel_load),
        .d    (sel_d),
        .q    (cur)
    );

    cfg_route #(
        .ADDR_W  (ADDR_W),
        .SEL_PORT(SEL_PORT),
        .WIN_PORT(WIN_PORT),
        .IDSEL_LO(IDSEL_LO),
        .IDSEL_N (IDSEL_N)
    ) u_route (
        .port_word(h_addr[ADDR_W-1:2]),
        .wide     (h_size[1]),
        .write    (h_write),
        .cur      (cur),
        .route    (route),
        .bridged  (bridged),
        .ad       (ad)
    );

    cfg_lanes #(
        .DATA_W(DATA_W)
    ) u_lanes (
        .off      (h_addr[1:0]),
        .size     (h_size),
        .wdata_in (h_wdata),
        .rdata_in (ds_rdata),
        .be       (be),
        .wdata_out(wlane),
        .rdata_out(ralign)
    );

    // Flags for accesses another agent completes.
    assign h_passthru = h_req && (route == RT_PASS);
    assign h_int_sel  = h_req && (route == RT_HOST);

    // Sequencer: local completion, downstream request, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            h_ready  <= 1'b0;
            h_rdata  <= '0;
            ds_valid <= 1'b0;
            ds_ad    <= '0;
            ds_cmd   <= '0;
            ds_be    <= '0;
            ds_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    h_ready <= 1'b0;
                    if (h_req) begin
                        case (route)
                            RT_SEL_WR: begin
                                h_ready <= 1'b1;
                                state   <= ST_DONE;
                            end
                            RT_SEL_RD: begin
                                h_rdata <= sel_image(cur);
                                h_ready <= 1'b1;
                                state   <= ST_DONE;
                            end
                            RT_NODEV: begin
                                if (!h_write) begin
                                    h_rdata <= '1;
                                end
                                h_ready <= 1'b1;
                                state   <= ST_DONE;
                            end
                            RT_CFG: begin
                                ds_valid <= 1'b1;
                                ds_ad    <= ad;
                                ds_cmd   <= {bridged, h_write};
                                ds_be    <= be;
                                ds_wdata <= wlane;
                                state    <= ST_WAIT;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (ds_ready) begin
                        ds_valid <= 1'b0;
                        if (!h_write) begin
                            h_rdata <= ralign;
                        end
                        h_ready <= 1'b1;
                        state   <= ST_DONE;
                    end
                end
                default: begin
                    h_ready <= 1'b0;
                    state   <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/pci_cfg_xlat_chk.sv
// Port-level protocol checker for the translator, bound to every instance.
// Assumes a synchronous active-low reset.
module pci_cfg_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        h_ready,
    input logic        h_passthru,
    input logic        h_int_sel,
    input logic        ds_valid,
    input logic        ds_ready,
    input logic [31:0] ds_ad,
    input logic [1:0]  ds_cmd,
    input logic [3:0]  ds_be,
    input logic [31:0] ds_wdata
);

    AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid && !ds_ready |=> ds_valid && $stable(ds_ad) && $stable(ds_cmd)
                                  && $stable(ds_be) && $stable(ds_wdata)); // R10

    AST_DS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid && ds_ready |=> h_ready && !ds_valid); // R10

    AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> !h_ready); // R10

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready); // R10

    AST_LOCAL_IDSEL: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid && !ds_cmd[1] |-> ($countones(ds_ad[31:11]) == 1)
                                   && (ds_ad[1:0] == 2'b00)); // R5

    AST_BRIDGE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid && ds_cmd[1] |-> (ds_ad[1:0] == 2'b01) && (ds_ad[23:16] != 8'h00)
                                  && (ds_ad[31:24] == 8'h00)); // R6

    AST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        h_passthru |-> !ds_valid && !h_ready); // R3

    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        h_int_sel |-> !ds_valid && !h_ready); // R7

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> (ds_be != 4'b0000)); // R9

endmodule

bind pci_cfg_xlat pci_cfg_xlat_chk chk_i (.*);

// File: tb/pci_cfg_xlat_tb_top.sv
`timescale 1ns/1ps
module pci_cfg_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic [15:0] h_addr = '0;
    logic [1:0]  h_size = '0;
    logic        h_write = 1'b0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic        h_passthru;
    logic        h_int_sel;
    logic        ds_valid;
    logic        ds_ready = 1'b0;
    logic [31:0] ds_ad;
    logic [1:0]  ds_cmd;
    logic [3:0]  ds_be;
    logic [31:0] ds_wdata;
    logic [31:0] ds_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;
    int wait_n = 0;
    int ds_count = 0;
    logic [31:0] cap_ad, cap_wd;
    logic [1:0]  cap_cmd;
    logic [3:0]  cap_be;

    logic [31:0] r_data;
    bit          r_got, r_pass, r_int;
    int          r_dsn, r_cyc;

    always #4 clk = ~clk;

    pci_cfg_xlat dut_i (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_addr(h_addr), .h_size(h_size),
        .h_write(h_write), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
        .h_passthru(h_passthru), .h_int_sel(h_int_sel), .ds_valid(ds_valid),
        .ds_ready(ds_ready), .ds_ad(ds_ad), .ds_cmd(ds_cmd), .ds_be(ds_be),
        .ds_wdata(ds_wdata), .ds_rdata(ds_rdata)
    );

    function automatic logic [31:0] resp(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96F0;
    endfunction

    // Downstream target with a programmable number of wait cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            ds_ready = 1'b0;
            wait_n = 0;
        end else if (ds_valid && !ds_ready) begin
            if (wait_n >= lat) begin
                ds_ready = 1'b1;
                ds_rdata = resp(ds_ad);
                cap_ad = ds_ad; cap_cmd = ds_cmd; cap_be = ds_be; cap_wd = ds_wdata;
                ds_count++;
                wait_n = 0;
            end else begin
                wait_n++;
            end
        end else begin
            ds_ready = 1'b0;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic [1:0] sz,
                          input bit wr, input logic [31:0] wd);
        int n0;
        @(negedge clk);
        h_addr = a; h_size = sz; h_write = wr; h_wdata = wd; h_req = 1'b1;
        r_got = 0; r_pass = 0; r_int = 0; r_data = '0; r_cyc = 0;
        n0 = ds_count;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (h_passthru) r_pass = 1;
            if (h_int_sel) r_int = 1;
            if (h_ready) begin
                r_got = 1; r_data = h_rdata; r_cyc = i + 1;
                break;
            end
        end
        h_req = 1'b0;
        r_dsn = ds_count - n0;
    endtask

    task automatic set_sel(input logic [31:0] v);
        access(16'h0CF8, 2'b10, 1, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] exp_ad, sv;
        repeat (4) @(negedge clk);
        chk("R1", "h_ready in reset", {31'b0, h_ready}, 0);
        chk("R1", "ds_valid in reset", {31'b0, ds_valid}, 0);
        rst_n = 1'b1;
        access(16'h0CF8, 2'b10, 0, 0);
        chk("R1", "selector after reset", r_data, 32'h0);

        // R2: store and read back with reserved/type bits zeroed
        foreach (sv[k]) ;
        for (int p = 0; p < 4; p++) begin
            logic [31:0] v;
            v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h7F00_0003 :
                (p == 2) ? 32'h8012_3456 : 32'h0AA5_5AA5;
            set_sel(v);
            chk("R2", "write completes", {31'b0, r_got}, 1);
            access(16'h0CF8, 2'b10, 0, 0);
            chk("R2", "readback", r_data, v & 32'h80FF_FFFC);
        end

        // R3: narrow selector accesses pass through, selector untouched
        set_sel(32'h8001_0800);
        for (int o = 0; o < 4; o++) begin
            access(16'h0CF8 + 16'(o), 2'b00, 1, 32'hFFFF_FFFF);
            chk("R3", "byte pass", {30'b0, r_pass, r_got}, 32'h2);
        end
        for (int o = 0; o < 4; o += 2) begin
            access(16'h0CF8 + 16'(o), 2'b01, (o == 0), 32'h0000_FFFF);
            chk("R3", "word pass", {30'b0, r_pass, r_got}, 32'h2);
        end
        access(16'h0CF8, 2'b10, 0, 0);
        chk("R3", "selector unchanged", r_data, 32'h8001_0800);

        // R4: disabled window
        set_sel(32'h0000_0800);
        access(16'h0CFC, 2'b10, 0, 0);
        chk("R4", "pass/ready", {30'b0, r_pass, r_got}, 32'h2);
        chk("R4", "no request", r_dsn, 0);

        // R5 / R10: local requests, every IDSEL device
        for (int d = 1; d <= 21; d++) begin
            for (int f = 0; f < 8; f += 3) begin
                logic [5:0] rg;
                rg = 6'((d * 3 + f) % 64);
                lat = (d + f) % 4;
                set_sel({1'b1, 7'h7F, 8'h00, 5'(d), 3'(f), rg, 2'b11});
                exp_ad = (32'h1 << (10 + d)) | {21'b0, 3'(f), rg, 2'b00};
                access(16'h0CFC, 2'b10, 0, 0);
                chk("R5", "local ad", ds_count > 0 ? cap_ad : 32'hX, exp_ad);
                chk("R5", "local read cmd", {30'b0, cap_cmd}, 0);
                chk("R5", "local read data", r_data, resp(exp_ad));
                chk("R10", "one request", r_dsn, 1);
                chk("R10", "completion cycle", r_cyc, lat + 2);
                access(16'h0CFC, 2'b10, 1, 32'hC0DE_0000 + 32'(d));
                chk("R5", "local write cmd", {30'b0, cap_cmd}, 1);
                chk("R9", "dword wdata", cap_wd, 32'hC0DE_0000 + 32'(d));
                chk("R9", "dword be", {28'b0, cap_be}, 32'hF);
            end
        end
        lat = 1;

        // R6: bridged requests
        for (int b = 0; b < 3; b++) begin
            for (int d = 0; d < 3; d++) begin
                logic [7:0] bus;
                logic [4:0] dv;
                bus = (b == 0) ? 8'h01 : (b == 1) ? 8'h5A : 8'hFF;
                dv = (d == 0) ? 5'd0 : (d == 1) ? 5'd7 : 5'd31;
                set_sel({1'b1, 7'h00, bus, dv, 3'd3, 6'h2A, 2'b00});
                exp_ad = {8'h00, bus, dv, 3'd3, 6'h2A, 2'b01};
                access(16'h0CFC, 2'b10, 0, 0);
                chk("R6", "bridged ad", cap_ad, exp_ad);
                chk("R6", "bridged read cmd", {30'b0, cap_cmd}, 2);
                chk("R6", "bridged read data", r_data, resp(exp_ad));
                access(16'h0CFC, 2'b10, 1, 32'h1234_5678);
                chk("R6", "bridged write cmd", {30'b0, cap_cmd}, 3);
            end
        end

        // R7: host's own space
        set_sel(32'h8000_0000);
        for (int w = 0; w < 2; w++) begin
            access(16'h0CFC, 2'b10, w[0], 0);
            chk("R7", "int_sel/ready", {30'b0, r_int, r_got}, 32'h2);
            chk("R7", "no request", r_dsn, 0);
        end

        // R8: devices without an IDSEL line
        for (int d = 22; d < 32; d++) begin
            set_sel({1'b1, 7'h00, 8'h00, 5'(d), 3'd1, 6'h04, 2'b00});
            access(16'h0CFC, 2'b10, 0, 0);
            chk("R8", "empty read", r_data, 32'hFFFF_FFFF);
            chk("R8", "read no request", r_dsn, 0);
            access(16'h0CFC, 2'b10, 1, 32'h5555_AAAA);
            chk("R8", "write completes", {31'b0, r_got}, 1);
            chk("R8", "write no request", r_dsn, 0);
        end

        // R9: byte and word lanes
        set_sel({1'b1, 7'h00, 8'h00, 5'd3, 3'd2, 6'h10, 2'b00});
        exp_ad = (32'h1 << 13) | {21'b0, 3'd2, 6'h10, 2'b00};
        for (int o = 0; o < 4; o++) begin
            access(16'h0CFC + 16'(o), 2'b00, 1, 32'hFFFF_FF00 | 32'(8'hA5 + o));
            chk("R9", "byte be", {28'b0, cap_be}, 32'h1 << o);
            chk("R9", "byte wdata", cap_wd, 32'(8'hA5 + o) << (8 * o));
            access(16'h0CFC + 16'(o), 2'b00, 0, 0);
            chk("R9", "byte rdata", r_data, (resp(exp_ad) >> (8 * o)) & 32'hFF);
        end
        for (int o = 0; o < 4; o += 2) begin
            access(16'h0CFC + 16'(o), 2'b01, 1, 32'hFFFF_BEEF);
            chk("R9", "word be", {28'b0, cap_be}, 32'h3 << o);
            chk("R9", "word wdata", cap_wd, 32'hBEEF << (8 * o));
            access(16'h0CFC + 16'(o), 2'b01, 0, 0);
            chk("R9", "word rdata", r_data, (resp(exp_ad) >> (8 * o)) & 32'hFFFF);
        end

        // R11: unrelated addresses
        for (int k = 0; k < 3; k++) begin
            access((k == 0) ? 16'h0CF4 : (k == 1) ? 16'h0D00 : 16'h0080, 2'b10, 0, 0);
            chk("R11", "pass/ready", {30'b0, r_pass, r_got}, 32'h2);
            chk("R11", "no request", r_dsn, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule